// File: doc/BRIEF.md
# Cascadable Four-Channel Countdown Timer Group

This block holds four 31-bit countdown timers that share one clock prescaler and one group control word. Software reaches every register through a single 32-bit write port with a combinational read. Each timer reloads from its base register every time it expires. At that moment it flips a toggle flag and pulls its own active-low, level-sensitive interrupt line low. The line stays low until software writes the timer's current-count register.

Two neighbouring timers can be joined into one long interval. The lower timer counts every prescaled tick. The upper timer counts down once each time the lower one wraps. The pair expires, and interrupts on the upper timer's line, only when both are exhausted. Each timer also has a vector/priority word and a destination word. These are plain storage.

Top module: `cascade_timer_group`

## Requirements
- R1: After reset, every base register reads 0x8000_0000, every current count reads 0, the control word reads 0 and all four `irq_n` lines are high.
- R2: Writing a base register with bit 31 clear, while that register's bit 31 was set, loads the count from the written low 31 bits. A base write while the timer runs leaves the count unchanged.
- R3: A running standalone timer (base bit 31 clear) decrements once per prescaled tick. With base bit 31 set, its count holds.
- R4: Control bits 9:8 select the tick period: 00 gives 8 clocks, 01 gives 16, 10 gives 32 and 11 gives 64. A control write that changes this field restarts the prescaler, so the first tick falls exactly one full period after the clock edge of that write.
- R5: A tick that finds a standalone count of 1 reloads the base value, inverts the toggle flag (bit 31 of the current-count read) and drives that timer's `irq_n` low.
- R6: Any write to a current-count register (offset 0 in the timer's window) clears its count, its toggle flag and its pending interrupt.
- R7: A tick that finds a standalone count of 0 reloads the base value silently, with no toggle and no interrupt.
- R8: Control bits 0, 1 and 2 join timers 0–1, 1–2 and 2–3. When two overlapping pairs are both requested, the lower-numbered pair wins and the other timer runs alone. Bits 24–26 are stored and read back. Only bits 0–2, 8–9 and 24–26 hold data; all other control bits read 0.
- R9: A joined pair runs while the upper timer's base bit 31 is clear. The lower count decrements on every tick. When the lower count is 0 and the upper count is not 0, a tick sets the lower count to 0x7FFF_FFFF and decrements the upper count.
- R10: A tick that finds the lower count at 1 and the upper count at 0 reloads both from their bases. It flips the upper timer's toggle flag and drives only the upper timer's `irq_n` low.
- R11: Timer n occupies bytes n*64 upward: current count at +0, base at +16, vector/priority at +32, destination at +48. The control word sits at 0x100. Vector and destination words read back as written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_n | output | 4 | Per-timer active-low level interrupt |

## Verification
The bench runs single timers at divide-by-8, 16 and 64 with small base values. This separates an off-by-one error in the tick period from an off-by-one error in the count. Counts of 1 and 0 at a tick are both reached, so an expiry cannot be confused with a silent reload after a clear. Joined pairs are started in two states: one where the lower timer wraps into the upper timer, and one where both hit zero together. Together these show which timer's line fires. A final run requests two overlapping pairs at once and checks that the losing timer behaves as a standalone counter.

// File: rtl/cascade_timer_group.sv
module cascade_timer_group (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [8:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [3:0]  irq_n
);

  localparam int          NT        = 4;
  localparam logic [8:0]  CTRL_ADDR = 9'h100;
  localparam logic [31:0] CTRL_MASK = 32'h0700_0307;

  logic [31:0] ctrl;
  logic [5:0]  pcnt, div_m1;
  logic        tick;
  logic [30:0] cnt  [NT];
  logic [31:0] base [NT];
  logic [31:0] vec  [NT];
  logic [31:0] dst  [NT];
  logic        tog  [NT];
  logic        pend [NT];
  logic [2:0]  casc;
  logic [3:0]  lo, hi, busy, wr_cur, wr_base;
  logic        t_hit, ctrl_wr;
  logic [1:0]  t_idx, t_reg;

  assign t_hit   = !addr[8] && addr[3:0] == 4'd0;
  assign t_idx   = addr[7:6];
  assign t_reg   = addr[5:4];
  assign ctrl_wr = wr_en && addr == CTRL_ADDR;

  always_comb
    case (ctrl[9:8])
      2'd0:    div_m1 = 6'd7;
      2'd1:    div_m1 = 6'd15;
      2'd2:    div_m1 = 6'd31;
      default: div_m1 = 6'd63;
    endcase

  assign tick    = pcnt == div_m1;
  assign casc[0] = ctrl[0];
  assign casc[1] = ctrl[1] & ~casc[0];
  assign casc[2] = ctrl[2] & ~casc[1];
  assign lo      = {1'b0, casc};
  assign hi      = {casc, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      pcnt <= '0;
    end else begin
      if (ctrl_wr) ctrl <= wdata & CTRL_MASK;
      if (ctrl_wr && wdata[9:8] != ctrl[9:8]) pcnt <= '0;
      else if (tick)                          pcnt <= '0;
      else                                    pcnt <= pcnt + 6'd1;
    end

  assert_prescale_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= div_m1);

  for (genvar i = 0; i < NT; i++) begin : g_t
    localparam int DN = (i == 0) ? 0 : i - 1;
    localparam int UP = (i == NT - 1) ? NT - 1 : i + 1;

    assign wr_cur[i]  = wr_en && t_hit && t_idx == 2'(i) && t_reg == 2'd0;
    assign wr_base[i] = wr_en && t_hit && t_idx == 2'(i) && t_reg == 2'd1;
    assign busy[i]    = lo[i] ? !base[UP][31] : !base[i][31];
    assign irq_n[i]   = !pend[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt[i]  <= '0;
        base[i] <= 32'h8000_0000;
        tog[i]  <= 1'b0;
        pend[i] <= 1'b0;
      end else if (wr_cur[i]) begin
        cnt[i]  <= '0;
        tog[i]  <= 1'b0;
        pend[i] <= 1'b0;
      end else if (wr_base[i]) begin
        base[i] <= wdata;
        if (base[i][31] && !wdata[31]) cnt[i] <= wdata[30:0];
      end else if (tick && busy[i]) begin
        if (lo[i]) begin
          if (cnt[i] > 31'd1)        cnt[i] <= cnt[i] - 31'd1;
          else if (cnt[UP] != '0)    cnt[i] <= (cnt[i] == 31'd1) ? 31'd0 : '1;
          else                       cnt[i] <= base[i][30:0];
        end else if (hi[i]) begin
          if (cnt[DN] == '0 && cnt[i] != '0)
            cnt[i] <= cnt[i] - 31'd1;
          else if (cnt[i] == '0 && cnt[DN] <= 31'd1) begin
            cnt[i] <= base[i][30:0];
            if (cnt[DN] == 31'd1) begin
              tog[i]  <= !tog[i];
              pend[i] <= 1'b1;
            end
          end
        end else begin
          if (cnt[i] > 31'd1) cnt[i] <= cnt[i] - 31'd1;
          else begin
            cnt[i] <= base[i][30:0];
            if (cnt[i] == 31'd1) begin
              tog[i]  <= !tog[i];
              pend[i] <= 1'b1;
            end
          end
        end
      end

    assert_irq_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> $past(tick));
    assert_lower_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> !$past(lo[i]));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cur[i] |=> !pend[i]);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[i] && !wr_cur[i] && !wr_base[i]) |=> $stable(cnt[i]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) begin
        vec[k] <= '0;
        dst[k] <= '0;
      end
    end else if (wr_en && t_hit) begin
      if (t_reg == 2'd2) vec[t_idx] <= wdata;
      if (t_reg == 2'd3) dst[t_idx] <= wdata;
    end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) rdata = ctrl;
    else if (t_hit)
      case (t_reg)
        2'd0:    rdata = {tog[t_idx], cnt[t_idx]};
        2'd1:    rdata = base[t_idx];
        2'd2:    rdata = vec[t_idx];
        default: rdata = dst[t_idx];
      endcase
  end

endmodule

// File: tb/tb_cascade_timer_group.sv
module tb_cascade_timer_group;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_n;
  int          cyc = 0;
  int          nchk = 0;
  int          nbad = 0;
  int          e;

  cascade_timer_group dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                           .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic [3:0] exp);
    chk(req, {28'd0, irq_n}, {28'd0, exp});
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic sync(input logic [31:0] c);
    wr(9'h100, c ^ 32'h100);
    wr(9'h100, c);
    e = cyc;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 9'h100, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd_chk("R1 base", 9'(i * 64 + 16), 32'h8000_0000);
      rd_chk("R1 count", 9'(i * 64), 32'h0);
    end
    irq_chk("R1 irq", 4'hF);
  endtask

  task automatic t_single_div8;
    sync(32'h0);
    wr(9'h090, 32'd3);
    wait_to(e + 8);  rd_chk("R3 count after 1 tick", 9'h080, 32'd2);
    wait_to(e + 16); rd_chk("R3 count after 2 ticks", 9'h080, 32'd1);
    wait_to(e + 23); irq_chk("R5 no irq early", 4'hF);
    wait_to(e + 24); irq_chk("R5 irq timer2", 4'b1011);
    rd_chk("R5 reload and toggle", 9'h080, 32'h8000_0003);
    wr(9'h080, 32'h0);
    irq_chk("R6 irq cleared", 4'hF);
    rd_chk("R6 count cleared", 9'h080, 32'h0);
    wait_to(e + 32);
    rd_chk("R7 silent reload", 9'h080, 32'd3);
    irq_chk("R7 no irq", 4'hF);
    wait_to(e + 40); rd_chk("R3 counting resumes", 9'h080, 32'd2);
    wr(9'h090, 32'h8000_0003);
    wait_to(e + 60); rd_chk("R3 held while stopped", 9'h080, 32'd2);
    wr(9'h080, 32'h0);
  endtask

  task automatic t_div16;
    sync(32'h100);
    wr(9'h010, 32'd2);
    wait_to(e + 15); rd_chk("R4 no tick before 16", 9'h000, 32'd2);
    wait_to(e + 16); rd_chk("R4 tick at 16", 9'h000, 32'd1);
    wait_to(e + 31); irq_chk("R4 no irq before 32", 4'hF);
    wait_to(e + 32); irq_chk("R5 irq timer0", 4'b1110);
    rd_chk("R5 toggle timer0", 9'h000, 32'h8000_0002);
    wr(9'h010, 32'h8000_0002);
    wr(9'h000, 32'h0);
  endtask

  task automatic t_div64;
    sync(32'h300);
    wr(9'h0D0, 32'd1);
    wait_to(e + 63); irq_chk("R4 no irq before 64", 4'hF);
    wait_to(e + 64); irq_chk("R4 irq at 64", 4'b0111);
    wr(9'h0D0, 32'h8000_0001);
    wr(9'h0C0, 32'h0);
  endtask

  task automatic t_base_running;
    sync(32'h0);
    wr(9'h0D0, 32'd5);
    wait_to(e + 8); rd_chk("R2 loaded then ticked", 9'h0C0, 32'd4);
    wr(9'h0D0, 32'd9);
    rd_chk("R2 running write keeps count", 9'h0C0, 32'd4);
    wait_to(e + 16); rd_chk("R2 still counting", 9'h0C0, 32'd3);
    wr(9'h0D0, 32'h8000_0009);
    wr(9'h0C0, 32'h0);
  endtask

  task automatic t_casc_expire;
    sync(32'h1);
    wr(9'h010, 32'd2);
    wr(9'h050, 32'd0);
    wait_to(e + 8);
    rd_chk("R9 lower ticks", 9'h000, 32'd1);
    rd_chk("R9 upper holds", 9'h040, 32'd0);
    wait_to(e + 15); irq_chk("R10 no early irq", 4'hF);
    wait_to(e + 16); irq_chk("R10 only upper irq", 4'b1101);
    rd_chk("R10 upper toggled", 9'h040, 32'h8000_0000);
    rd_chk("R10 lower reloaded", 9'h000, 32'd2);
    wr(9'h050, 32'h8000_0000);
    wr(9'h010, 32'h8000_0002);
    wr(9'h040, 32'h0);
    wr(9'h000, 32'h0);
  endtask

  task automatic t_casc_wrap;
    sync(32'h1);
    wr(9'h010, 32'd0);
    wr(9'h050, 32'd1);
    wait_to(e + 8);
    rd_chk("R9 lower wraps", 9'h000, 32'h7FFF_FFFF);
    rd_chk("R9 upper decrements", 9'h040, 32'd0);
    irq_chk("R9 no irq on wrap", 4'hF);
    wait_to(e + 16);
    rd_chk("R9 lower keeps counting", 9'h000, 32'h7FFF_FFFE);
    wr(9'h050, 32'h8000_0001);
    wr(9'h010, 32'h8000_0000);
    wr(9'h040, 32'h0);
    wr(9'h000, 32'h0);
  endtask

  task automatic t_priority;
    sync(32'h3);
    rd_chk("R8 ctrl readback", 9'h100, 32'h3);
    wr(9'h090, 32'd2);
    wait_to(e + 8);  rd_chk("R8 timer2 alone", 9'h080, 32'd1);
    wait_to(e + 16); irq_chk("R8 timer2 standalone expiry", 4'b1011);
    wr(9'h090, 32'h8000_0002);
    wr(9'h080, 32'h0);
    wr(9'h100, 32'h0);
  endtask

  task automatic t_storage;
    wr(9'h100, 32'hFFFF_FFFF);
    rd_chk("R8 ctrl mask", 9'h100, 32'h0700_0307);
    wr(9'h100, 32'h0);
    wr(9'h020, 32'hA5A5_1234);
    wr(9'h0F0, 32'h1234_5678);
    rd_chk("R11 vector timer0", 9'h020, 32'hA5A5_1234);
    rd_chk("R11 dest timer3", 9'h0F0, 32'h1234_5678);
    rd_chk("R11 dest timer0 untouched", 9'h030, 32'h0);
    rd_chk("R11 unmapped ctrl area", 9'h104, 32'h0);
    rd_chk("R11 unmapped in window", 9'h008, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single_div8;
    t_div16;
    t_div64;
    t_base_running;
    t_casc_expire;
    t_casc_wrap;
    t_priority;
    t_storage;
    irq_chk("R6 all lines idle at end", 4'hF);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule